// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters on one line shared by many listeners. A sample tick at sixteen times the bit rate drives its timing. The block takes three samples in the middle of each bit and sets the bit by majority vote. If the samples disagree, the character is marked as noisy. Bits collect in a shift register. When a character completes, the whole byte moves into a separate receive register, so the next character can shift in while software has not yet fetched the last one.

For multidrop traffic, software can put the receiver to sleep after it sees that a message is addressed elsewhere. While asleep, the receiver raises no receive flag and delivers no data. Hardware wakes it by one of two methods, chosen by a control bit. The first method wakes it when the line has been idle for a full frame time. The second wakes it when a character arrives whose most significant data bit is 1. Software reaches the block through a small register port with a data register, a status register and a control register.

Top module: `mdrop_rx`

## Requirements
- R1: After reset all five flags, the sleep bit and the wake-method bit are 0, and the status and control registers read 0.
- R2: A frame is one low start bit, 8 data bits sent LSB first, and one stop bit. On the stop sample, the byte moves to the receive register (address 0) and `dataFull` (status bit 0) is set. A second character can be received completely while the first is still waiting to be read.
- R3: A bit is taken as the majority of three samples at mid-bit. If one sample disagrees, the bit value is still correct and `noisy` (status bit 3) is set for that character.
- R4: If the start bit does not have a low majority at mid-bit, it is discarded. No character results, and the receiver goes back to looking for a falling edge.
- R5: A low stop bit sets `framing` (status bit 4), and the character is still transferred.
- R6: If a character completes while `dataFull` is set, `overrun` (status bit 2) is set and the receive register keeps the older byte.
- R7: A read of the status register (address 1) followed by a read of the data register (address 0) clears `dataFull`, `lineIdle`, `overrun`, `noisy` and `framing`.
- R8: `lineIdle` (status bit 1) is set after 10 bit times of continuous high line that follow a received character. It is not set again until another character has been received.
- R9: Writing control (address 2) bit 0 = 1 puts the receiver to sleep. While asleep, no flag can become set and no byte is transferred, except for the waking character described in R11.
- R10: With control bit 1 = 0 (idle-line method), an idle detection while asleep clears the sleep bit without setting `lineIdle`. The next frame is then received normally.
- R11: With control bit 1 = 1 (address-mark method), a character with data bit 7 = 1 clears the sleep bit and is received with normal flags. Characters with bit 7 = 0, and idle periods, leave the receiver asleep.
- R12: A register write can clear the sleep bit directly, and the control register reads back both control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| regSel | input | 2 | Register address: 0 data, 1 status, 2 control |
| regRd | input | 1 | Read strobe for the addressed register |
| regWr | input | 1 | Write strobe for the addressed register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed register |
| rxByte | output | 8 | Receive data register |
| dataFull | output | 1 | Unread byte present |
| lineIdle | output | 1 | Idle line detected |
| overrun | output | 1 | Character lost because the receive register was full |
| noisy | output | 1 | Sample disagreement in the current byte |
| framing | output | 1 | Stop bit sampled low |
| sleeping | output | 1 | Sleep bit |

## Verification
Counted from the frame's first low tick, a character's byte and flags appear about 155 sample ticks later: detection tick, plus nine bits, plus the third sample point of the stop bit, plus the two-stage line synchronizer. The bench therefore compares them on a falling clock edge only after the full 160-tick frame has been driven. A scoreboard monitor pops the expected byte at the rising edge of `dataFull`. Idle detection is due 160 ticks after the stop sample, so idle and wakeup checks wait 170 ticks. Flag clears take effect one clock after the data read, and the bench samples them at the following falling edge.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  localparam logic [1:0] REG_DATA    = 2'd0;
  localparam logic [1:0] REG_STATUS  = 2'd1;
  localparam logic [1:0] REG_CONTROL = 2'd2;

  typedef enum logic {HUNT, RECV} rxState_e;

  // strobes from bit-timing control to the byte datapath
  typedef struct packed {
    logic shiftEn;     // a data bit has been voted
    logic bitVal;      // voted value
    logic frameDone;   // stop bit voted, character complete
    logic frameNoisy;  // some sample disagreed within this frame
    logic stopLow;     // stop bit voted low
    logic idleHit;     // idle period reached after a character
  } rxStrobe_t;

endpackage

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl
  import mdrop_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  output rxStrobe_t  stb
);

  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int S0         = MID - 1;
  localparam int S1         = MID;
  localparam int S2         = MID + 1;
  localparam int LAST       = OVERSAMPLE - 1;
  localparam int STOP_IDX   = DATA_BITS + 1;
  localparam int BIT_W      = $clog2(DATA_BITS + 2);
  localparam int IDLE_TICKS = OVERSAMPLE * IDLE_BITS;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineS;
  rxState_e               state;
  logic [CNT_W-1:0]       phase;
  logic [BIT_W-1:0]       bitIdx;
  logic                   smpA, smpB;
  logic                   noiseAcc;
  logic [IDLE_W-1:0]      idleCnt;
  logic                   armed;
  logic                   vote, split, decide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  // third sample is the live line; the first two are held
  assign vote   = (smpA & smpB) | (smpA & lineS) | (smpB & lineS);
  assign split  = !((smpA == smpB) && (smpB == lineS));
  assign decide = sampleTick && (state == RECV) && (phase == CNT_W'(S2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= HUNT;
      phase    <= '0;
      bitIdx   <= '0;
      smpA     <= 1'b1;
      smpB     <= 1'b1;
      noiseAcc <= 1'b0;
    end else if (sampleTick) begin
      case (state)
        HUNT: if (!lineS) begin
          state    <= RECV;
          phase    <= '0;
          bitIdx   <= '0;
          noiseAcc <= 1'b0;
        end
        RECV: begin
          phase <= (phase == CNT_W'(LAST)) ? '0 : phase + 1'b1;
          if (phase == CNT_W'(S0)) smpA <= lineS;
          if (phase == CNT_W'(S1)) smpB <= lineS;
          if (phase == CNT_W'(LAST)) bitIdx <= bitIdx + 1'b1;
          if (decide) begin
            noiseAcc <= noiseAcc | split;
            if ((bitIdx == '0) && vote)       state <= HUNT;
            if (bitIdx == BIT_W'(STOP_IDX))   state <= HUNT;
          end
        end
        default: state <= HUNT;
      endcase
    end
  end

  // idle detection: high ticks while hunting, armed by a completed frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      armed   <= 1'b0;
    end else begin
      if ((state != HUNT) || !lineS)                         idleCnt <= '0;
      else if (sampleTick && (idleCnt != IDLE_W'(IDLE_TICKS))) idleCnt <= idleCnt + 1'b1;
      if (stb.frameDone)    armed <= 1'b1;
      else if (stb.idleHit) armed <= 1'b0;
    end
  end

  always_comb begin
    stb            = '0;
    stb.bitVal     = vote;
    stb.shiftEn    = decide && (bitIdx >= BIT_W'(1)) && (bitIdx <= BIT_W'(DATA_BITS));
    stb.frameDone  = decide && (bitIdx == BIT_W'(STOP_IDX));
    stb.frameNoisy = noiseAcc | split;
    stb.stopLow    = !vote;
    stb.idleHit    = sampleTick && (state == HUNT) && lineS && armed &&
                     (idleCnt == IDLE_W'(IDLE_TICKS - 1));
  end

  // R2: a completed character is reported for exactly one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> !stb.frameDone);

  // R4: a start bit voted high drops back to hunting
  a_r4_false_start: assert property (@(posedge clk) disable iff (!rstN)
    (decide && (bitIdx == '0) && vote) |=> (state == HUNT));

  // R8: idle is reported once per armed period
  a_r8_idle_once: assert property (@(posedge clk) disable iff (!rstN)
    stb.idleHit |=> !stb.idleHit);

endmodule

// File: rtl/mdrop_rx_dp.sv
module mdrop_rx_dp
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            stb,
  input  logic [1:0]           regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_BITS-1:0] regWdata,
  output logic [DATA_BITS-1:0] regRdata,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 dataFull,
  output logic                 lineIdle,
  output logic                 overrun,
  output logic                 noisy,
  output logic                 framing,
  output logic                 doze
);

  logic [DATA_BITS-1:0] shiftQ;
  logic wakeByMark, statusSeen;
  logic markHit, accept, statusRd, dataRd, ctrlWr, clearSeq;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_BITS-1:2];

  assign statusRd = regRd && (regSel == REG_STATUS);
  assign dataRd   = regRd && (regSel == REG_DATA);
  assign ctrlWr   = regWr && (regSel == REG_CONTROL);
  assign clearSeq = dataRd && statusSeen;
  assign markHit  = stb.frameDone && wakeByMark && shiftQ[DATA_BITS-1];
  assign accept   = stb.frameDone && (!doze || markHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else if (stb.shiftEn) shiftQ <= {stb.bitVal, shiftQ[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte     <= '0;
      dataFull   <= 1'b0;
      lineIdle   <= 1'b0;
      overrun    <= 1'b0;
      noisy      <= 1'b0;
      framing    <= 1'b0;
      statusSeen <= 1'b0;
      doze       <= 1'b0;
      wakeByMark <= 1'b0;
    end else begin
      if (statusRd)    statusSeen <= 1'b1;
      else if (dataRd) statusSeen <= 1'b0;

      if (clearSeq) begin
        dataFull <= 1'b0;
        lineIdle <= 1'b0;
        overrun  <= 1'b0;
        noisy    <= 1'b0;
        framing  <= 1'b0;
      end

      if (accept) begin
        if (dataFull && !clearSeq) begin
          overrun <= 1'b1;
        end else begin
          rxByte   <= shiftQ;
          dataFull <= 1'b1;
          noisy    <= stb.frameNoisy;
          framing  <= stb.stopLow;
        end
      end

      if (stb.idleHit && !doze) lineIdle <= 1'b1;

      if (ctrlWr) begin
        doze       <= regWdata[0];
        wakeByMark <= regWdata[1];
      end else if (doze && markHit) begin
        doze <= 1'b0;
      end else if (doze && !wakeByMark && stb.idleHit) begin
        doze <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regSel)
      REG_DATA:    regRdata = rxByte;
      REG_STATUS:  regRdata = DATA_BITS'({framing, noisy, overrun, lineIdle, dataFull});
      REG_CONTROL: regRdata = DATA_BITS'({wakeByMark, doze});
      default:     regRdata = '0;
    endcase
  end

  // R6: an overrun leaves the held byte untouched
  a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && stb.frameDone && !clearSeq) |=> $stable(rxByte));

  // R7: the status-then-data read sequence empties the buffer
  a_r7_clear_seq: assert property (@(posedge clk) disable iff (!rstN)
    (clearSeq && !stb.frameDone) |=> (!dataFull && !overrun && !lineIdle));

  // R9: nothing rises while asleep unless a mark character wakes the receiver
  a_r9_asleep_no_flags: assert property (@(posedge clk) disable iff (!rstN)
    (doze && !markHit) |=> !($rose(dataFull) || $rose(lineIdle) || $rose(overrun) ||
                             $rose(noisy) || $rose(framing)));

  // R10: idle-line method wakes on idle detection
  a_r10_idle_wake: assert property (@(posedge clk) disable iff (!rstN)
    (doze && !wakeByMark && stb.idleHit && !ctrlWr) |=> (!doze && !$rose(lineIdle)));

  // R11: address-mark method wakes and delivers the marked character
  a_r11_mark_wake: assert property (@(posedge clk) disable iff (!rstN)
    (doze && markHit && !ctrlWr) |=> (!doze && dataFull));

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic [1:0]           regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_BITS-1:0] regWdata,
  output logic [DATA_BITS-1:0] regRdata,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 dataFull,
  output logic                 lineIdle,
  output logic                 overrun,
  output logic                 noisy,
  output logic                 framing,
  output logic                 sleeping
);

  rxStrobe_t stb;

  mdrop_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS),
    .IDLE_BITS  (IDLE_BITS),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxLine    (rxLine),
    .stb       (stb)
  );

  mdrop_rx_dp #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .regSel  (regSel),
    .regRd   (regRd),
    .regWr   (regWr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .rxByte  (rxByte),
    .dataFull(dataFull),
    .lineIdle(lineIdle),
    .overrun (overrun),
    .noisy   (noisy),
    .framing (framing),
    .doze    (sleeping)
  );

endmodule

// File: tb/mdrop_rx_bench.sv
module mdrop_rx_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic       sampleTick = 1'b0;
  logic [1:0] divCnt = 2'd0;
  logic       rxLine;
  logic [1:0] regSel;
  logic       regRd, regWr;
  logic [7:0] regWdata;
  logic [7:0] regRdata, rxByte;
  logic       dataFull, lineIdle, overrun, noisy, framing, sleeping;

  int vectors = 0;
  int miscompares = 0;

  mdrop_rx u_mdrop_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .rxByte(rxByte), .dataFull(dataFull),
    .lineIdle(lineIdle), .overrun(overrun), .noisy(noisy),
    .framing(framing), .sleeping(sleeping)
  );

  // sample tick every fourth clock
  always @(posedge clk) begin
    divCnt     <= divCnt + 2'd1;
    sampleTick <= (divCnt == 2'd3);
  end

  typedef struct {
    logic [7:0] data;
    logic       nf;
    logic       fe;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(string req, string what, logic [31:0] actual, logic [31:0] expected);
    vectors++;
    if (actual !== expected) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  // monitor: each new byte must match the head of the scoreboard queue
  logic prevFull = 1'b0;
  always @(negedge clk) begin
    expItem_t e;
    if (rstN === 1'b1 && dataFull && !prevFull) begin
      if (expQ.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R9 unexpected transfer: actual 0x%0h expected none", rxByte);
      end else begin
        e = expQ.pop_front();
        check(e.req, "received byte", rxByte, e.data);
        check(e.req, "noise flag", noisy, e.nf);
        check(e.req, "framing flag", framing, e.fe);
      end
    end
    prevFull = dataFull;
  end

  task automatic holdTicks(int n);
    repeat (n) @(posedge clk iff sampleTick);
    @(negedge clk);
  endtask

  task automatic expectByte(logic [7:0] d, logic nf, logic fe, string req);
    expItem_t e;
    e.data = d; e.nf = nf; e.fe = fe; e.req = req;
    expQ.push_back(e);
  endtask

  // glitchBit: frame bit index (0 start, 1..8 data, 9 stop) with one flipped sample
  task automatic sendFrame(logic [7:0] b, logic stopBit = 1'b1, int glitchBit = -1);
    @(posedge clk iff sampleTick);
    @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      logic v;
      v = (j == 0) ? 1'b0 : (j == 9) ? stopBit : b[j-1];
      rxLine = v;
      if (j == glitchBit) begin
        holdTicks(8);
        rxLine = ~v;
        holdTicks(1);
        rxLine = v;
        holdTicks(7);
      end else begin
        holdTicks(16);
      end
    end
    rxLine = 1'b1;
  endtask

  task automatic readReg(logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel;
    regRd  = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic writeReg(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel   = sel;
    regWdata = d;
    regWr    = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic clearFlags();
    logic [7:0] v;
    readReg(2'd1, v);
    readReg(2'd0, v);
    @(negedge clk);
  endtask

  task automatic runAll();
    logic [7:0] v;
    rstN = 1'b0; rxLine = 1'b1; regSel = 2'd0; regRd = 1'b0; regWr = 1'b0; regWdata = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    readReg(2'd1, v); check("R1", "status after reset", v, 8'h00);
    readReg(2'd2, v); check("R1", "control after reset", v, 8'h00);
    check("R1", "sleep after reset", sleeping, 1'b0);

    // R2 frame and double buffering
    expectByte(8'hA5, 1'b0, 1'b0, "R2");
    sendFrame(8'hA5);
    readReg(2'd1, v); check("R2", "status after first byte", v, 8'h01);
    expectByte(8'h3C, 1'b0, 1'b0, "R2");
    fork
      sendFrame(8'h3C);
      begin
        holdTicks(40);
        readReg(2'd1, v);
        readReg(2'd0, v);
        check("R2", "first byte read while second arrives", v, 8'hA5);
        @(negedge clk);
        check("R7", "full cleared by read sequence", dataFull, 1'b0);
      end
    join
    readReg(2'd1, v); check("R2", "status after second byte", v, 8'h01);

    // R7 clear
    clearFlags();
    readReg(2'd1, v); check("R7", "status after clear", v, 8'h00);

    // R3 single disagreeing sample on data bit 3
    expectByte(8'h5A, 1'b1, 1'b0, "R3");
    sendFrame(8'h5A, 1'b1, 4);
    readReg(2'd1, v); check("R3", "status with noise", v, 8'h09);
    clearFlags();

    // R4 short low pulse is not a start bit
    @(negedge clk); rxLine = 1'b0; holdTicks(3); rxLine = 1'b1; holdTicks(20);
    check("R4", "no byte from false start", dataFull, 1'b0);
    expectByte(8'h81, 1'b0, 1'b0, "R4");
    sendFrame(8'h81);
    check("R4", "frame after false start", dataFull, 1'b1);
    clearFlags();

    // R5 low stop bit
    expectByte(8'h42, 1'b0, 1'b1, "R5");
    sendFrame(8'h42, 1'b0);
    holdTicks(20);
    readReg(2'd1, v); check("R5", "status with framing", v, 8'h11);
    clearFlags();

    // R6 overrun
    expectByte(8'h11, 1'b0, 1'b0, "R6");
    sendFrame(8'h11);
    sendFrame(8'h22);
    readReg(2'd1, v); check("R6", "status with overrun", v, 8'h05);
    check("R6", "older byte kept", rxByte, 8'h11);
    clearFlags();
    readReg(2'd1, v); check("R7", "overrun cleared", v, 8'h00);

    // R8 idle line
    holdTicks(170);
    readReg(2'd1, v); check("R8", "idle flag after idle time", v, 8'h02);
    clearFlags();
    check("R8", "idle flag cleared", lineIdle, 1'b0);
    holdTicks(200);
    check("R8", "idle not set again without a byte", lineIdle, 1'b0);

    // R9 / R10 sleep with idle-line wakeup
    writeReg(2'd2, 8'h01);
    readReg(2'd2, v); check("R12", "control readback", v, 8'h01);
    sendFrame(8'h33, 1'b1, 4);
    readReg(2'd1, v); check("R9", "no flags while asleep", v, 8'h00);
    check("R9", "still asleep in message", sleeping, 1'b1);
    sendFrame(8'h44);
    check("R9", "still asleep after back-to-back frame", sleeping, 1'b1);
    holdTicks(170);
    check("R10", "idle woke receiver", sleeping, 1'b0);
    check("R10", "idle flag not set on wakeup", lineIdle, 1'b0);
    expectByte(8'h66, 1'b0, 1'b0, "R10");
    sendFrame(8'h66);
    readReg(2'd1, v); check("R10", "frame after wakeup", v, 8'h01);
    clearFlags();

    // R11 address-mark wakeup
    writeReg(2'd2, 8'h03);
    sendFrame(8'h12);
    check("R11", "unmarked byte leaves receiver asleep", sleeping, 1'b1);
    holdTicks(170);
    check("R11", "idle does not wake in mark method", sleeping, 1'b1);
    readReg(2'd1, v); check("R9", "idle flag inhibited while asleep", v, 8'h00);
    expectByte(8'h93, 1'b0, 1'b0, "R11");
    sendFrame(8'h93);
    check("R11", "marked byte woke receiver", sleeping, 1'b0);
    readReg(2'd1, v); check("R11", "marked byte flagged", v, 8'h01);
    readReg(2'd2, v); check("R12", "method bit kept after wakeup", v, 8'h02);
    clearFlags();

    // R9 overrun inhibited while asleep
    expectByte(8'hC4, 1'b0, 1'b0, "R9");
    sendFrame(8'hC4);
    writeReg(2'd2, 8'h03);
    sendFrame(8'h05);
    readReg(2'd1, v); check("R9", "no overrun while asleep", v, 8'h01);
    check("R9", "byte untouched while asleep", rxByte, 8'hC4);
    clearFlags();

    // R12 software clear of sleep
    writeReg(2'd2, 8'h01);
    check("R12", "sleep set by write", sleeping, 1'b1);
    writeReg(2'd2, 8'h00);
    check("R12", "sleep cleared by write", sleeping, 1'b0);
    expectByte(8'h77, 1'b0, 1'b0, "R12");
    sendFrame(8'h77);
    readReg(2'd1, v); check("R12", "frame after software wake", v, 8'h01);
    clearFlags();

    holdTicks(4);
    check("R2", "all expected bytes seen", expQ.size(), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule